// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block gathers the interrupt sources of an embedded processor and hands the core a single request line together with a 5-bit code that names the most urgent source. There are eighteen sources. Two of them cannot be masked: a watchdog timeout and an external pin. The other sixteen can be masked: a stack overflow exception, a stack underflow exception, a software trigger, and thirteen numbered hardware request lines. Each hardware input is edge sensitive. A rising edge sets a pending bit, and that bit stays set until the core acknowledges the source or software clears it.

The core programs the block through a small register port with write enable, a 2-bit address and write data. Reads are combinational. Through this port software can set mask bits, read the pending bits, clear pending bits and raise the software interrupt. The block keeps the presented code stable until the core acknowledges it. One acknowledge retires exactly the presented source. On the next cycle the block offers the next source that is pending and not masked.

Top module: `fpic_top`

## Requirements
- R1: After reset, `intr_req_o` is 0 and `intr_vec_o` is 0. The pending register reads 0. The mask register reads 0x3FFFC, which means every maskable source is blocked.
- R2: The clock edge that first samples a hardware source input at 1, after it was sampled at 0, sets that source's pending bit. If the input stays high, the bit is not set again after it has been cleared.
- R3: Source codes, which are also the bit positions in the mask and pending registers: watchdog 0, external pin 1, stack overflow 2, stack underflow 3, software 4, request line n at 5+n. Among the sources that are pending and not masked, the one with the lowest code is presented.
- R4: Mask bits 0 and 1 cannot be written and always read 0. The watchdog and external-pin sources raise a request even when all other mask bits are set.
- R5: A set mask bit stops its source from being presented, but the source is still latched as pending. Clearing the mask bit makes the source eligible on the edge of that write.
- R6: While `intr_req_o` is 1 and `intr_ack_i` is 0, `intr_vec_o` holds its value, even if a source with a lower code becomes pending.
- R7: Acknowledge while a request is presented clears only the presented source's pending bit. The next eligible source is presented after that same edge. Acknowledge with no request has no effect.
- R8: Writing address 1 clears each pending bit whose write-data bit is 1. If this clears the presented source, the request drops or moves to the next eligible source.
- R9: Writing address 2 with data bit 0 set marks the software source (code 4) pending.
- R10: Address 0 holds the mask and can be read and written. Address 1 reads the pending bits. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wdt_evt_i | input | 1 | Watchdog timeout event (nonmaskable) |
| nmi_pin_i | input | 1 | External nonmaskable pin |
| stk_ovf_i | input | 1 | Stack overflow exception |
| stk_unf_i | input | 1 | Stack underflow exception |
| irq_i | input | 13 | Numbered hardware request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| intr_ack_i | input | 1 | Acknowledge of the presented source |
| intr_req_o | output | 1 | Interrupt request to the core |
| intr_vec_o | output | 5 | Code of the presented source |

## Verification
The hardest situation to create is a presented request held against a newly arrived higher-priority source, followed by an acknowledge that has to hand over to that newcomer on the very next edge. A second hard situation is a software clear that removes the presented source itself. The stimulus reaches the first by pulsing a request line, then pulsing the watchdog while the request is still unacknowledged, and only then acknowledging. It reaches the second by unmasking a source and then clearing that source through the pending register. A third sequence latches sources while they are masked, so that lifting the mask releases them in code order, one per acknowledge.

// File: rtl/fpic_pkg.sv
package fpic_pkg;
    localparam int FIXED_SRC = 5;
    localparam int SRC_WDT   = 0;
    localparam int SRC_NMI   = 1;
    localparam int SRC_OVF   = 2;
    localparam int SRC_UNF   = 3;
    localparam int SRC_SW    = 4;
    localparam int NMI_CNT   = 2;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_PEND = 2'd1,
        REG_CTRL = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/fpic_edge.sv
module fpic_edge #(
    parameter int W = 18
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/fpic_prio.sv
module fpic_prio #(
    parameter int N  = 18,
    parameter int VW = 5
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [VW-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                any_o = 1'b1;
                idx_o = VW'(i);
            end
        end
    end
endmodule

// File: rtl/fpic_top.sv
module fpic_top
    import fpic_pkg::*;
#(
    parameter int NUM_IRQ = 13,
    parameter int DATA_W  = 32,
    localparam int SRC_N  = FIXED_SRC + NUM_IRQ,
    localparam int VEC_W  = $clog2(SRC_N)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wdt_evt_i,
    input  logic               nmi_pin_i,
    input  logic               stk_ovf_i,
    input  logic               stk_unf_i,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               reg_we_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic               intr_ack_i,
    output logic               intr_req_o,
    output logic [VEC_W-1:0]   intr_vec_o
);
    localparam logic [SRC_N-1:0] MASKABLE = ~SRC_N'((1 << NMI_CNT) - 1);

    typedef struct packed {
        logic [SRC_N-1:0] pend;
        logic [SRC_N-1:0] mask;
        logic             req;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t st_d, st_q;

    logic [SRC_N-1:0] hw_lvl, rise_v, set_v, clr_v, cand_v;
    logic             win_any;
    logic [VEC_W-1:0] win_idx;
    logic             hold;

    // Hardware sources placed at their codes; the software slot has no pin.
    assign hw_lvl = {irq_i, 1'b0, stk_unf_i, stk_ovf_i, nmi_pin_i, wdt_evt_i};

    fpic_edge #(.W(SRC_N)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (hw_lvl),
        .rise_o (rise_v)
    );

    fpic_prio #(.N(SRC_N), .VW(VEC_W)) u_prio (
        .cand_i (cand_v),
        .any_o  (win_any),
        .idx_o  (win_idx)
    );

    always_comb begin
        st_d  = st_q;
        set_v = rise_v;
        clr_v = '0;

        if (reg_we_i && reg_addr_i == REG_CTRL && reg_wdata_i[0])
            set_v[SRC_SW] = 1'b1;
        if (reg_we_i && reg_addr_i == REG_PEND)
            clr_v = reg_wdata_i[SRC_N-1:0];
        if (st_q.req && intr_ack_i)
            clr_v[int'(st_q.vec)] = 1'b1;
        if (reg_we_i && reg_addr_i == REG_MASK)
            st_d.mask = reg_wdata_i[SRC_N-1:0] & MASKABLE;

        // A new edge wins over a clear in the same cycle.
        st_d.pend = (st_q.pend & ~clr_v) | set_v;
        cand_v    = st_d.pend & ~st_d.mask;
        hold      = st_q.req && !intr_ack_i && st_d.pend[int'(st_q.vec)];

        if (!hold) begin
            st_d.req = win_any;
            st_d.vec = win_idx;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pend <= '0;
            st_q.mask <= MASKABLE;
            st_q.req  <= 1'b0;
            st_q.vec  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            REG_MASK: reg_rdata_o[SRC_N-1:0] = st_q.mask;
            REG_PEND: reg_rdata_o[SRC_N-1:0] = st_q.pend;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign intr_req_o = st_q.req;
    assign intr_vec_o = st_q.vec;

    logic [SRC_N-1:0] pend_q, mask_q;
    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/fpic_checker.sv
module fpic_checker #(
    parameter int SRC_N = 18,
    parameter int VEC_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wdt_evt_i,
    input logic             reg_we_i,
    input logic             intr_ack_i,
    input logic             intr_req_o,
    input logic [VEC_W-1:0] intr_vec_o,
    input logic [SRC_N-1:0] pend_q,
    input logic [SRC_N-1:0] mask_q,
    input logic [SRC_N-1:0] set_v
);
    function automatic logic [SRC_N-1:0] below(input logic [VEC_W-1:0] v);
        return (SRC_N'(1) << v) - SRC_N'(1);
    endfunction

    a_r2_wdt_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_evt_i) |=> pend_q[0]);

    a_r3_top_choice: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(intr_req_o) |-> ((pend_q & ~mask_q & below(intr_vec_o)) == '0));

    a_r4_nmi_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_q[1:0] == 2'b00);

    a_r5_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(intr_req_o) |-> !mask_q[intr_vec_o]);

    a_r6_vec_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        intr_req_o && !intr_ack_i && !reg_we_i |=> intr_req_o && $stable(intr_vec_o));

    a_r7_ack_retires: assert property (@(posedge clk_i) disable iff (!rst_ni)
        intr_req_o && intr_ack_i && !set_v[intr_vec_o] |=> !pend_q[$past(intr_vec_o)]);

    a_r7_req_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        intr_req_o |-> pend_q[intr_vec_o]);
endmodule

bind fpic_top fpic_checker #(.SRC_N(SRC_N), .VEC_W(VEC_W)) u_fpic_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdt_evt_i  (wdt_evt_i),
    .reg_we_i   (reg_we_i),
    .intr_ack_i (intr_ack_i),
    .intr_req_o (intr_req_o),
    .intr_vec_o (intr_vec_o),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .set_v      (set_v)
);

// File: tb/test_fpic_top.sv
`timescale 1ns/1ps
module test_fpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt = 1'b0, nmi = 1'b0, ovf = 1'b0, unf = 1'b0;
    logic [12:0] irq = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack = 1'b0;
    logic        req;
    logic [4:0]  vec;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpic_top i_fpic_top (
        .clk_i(clk), .rst_ni(rst_n), .wdt_evt_i(wdt), .nmi_pin_i(nmi),
        .stk_ovf_i(ovf), .stk_unf_i(unf), .irq_i(irq), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .intr_ack_i(ack), .intr_req_o(req), .intr_vec_o(vec)
    );

    // Behavioural reference model
    bit [17:0] m_pend, m_mask, m_prev;
    bit        m_req;
    int        m_vec;

    always @(posedge clk) begin
        bit [17:0] lvl, setb, clrb;
        if (!rst_n) begin
            m_pend = '0; m_mask = 18'h3FFFC; m_prev = '0; m_req = 0; m_vec = 0;
        end else begin
            lvl = '0;
            lvl[0] = wdt; lvl[1] = nmi; lvl[2] = ovf; lvl[3] = unf;
            for (int n = 0; n < 13; n++) lvl[5+n] = irq[n];
            setb = lvl & ~m_prev;
            m_prev = lvl;
            if (we && addr == 2'd2 && wdata[0]) setb[4] = 1'b1;
            clrb = '0;
            if (we && addr == 2'd1) clrb = wdata[17:0];
            if (m_req && ack) clrb[m_vec] = 1'b1;
            if (we && addr == 2'd0) m_mask = wdata[17:0] & 18'h3FFFC;
            m_pend = (m_pend & ~clrb) | setb;
            if (!(m_req && !ack && m_pend[m_vec])) begin
                m_req = 0; m_vec = 0;
                for (int s = 0; s < 18; s++)
                    if (!m_req && m_pend[s] && !m_mask[s]) begin m_req = 1; m_vec = s; end
            end
        end
    end

    task automatic eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            eq("R3 R6 R7 model req", int'(req), int'(m_req));
            if (m_req) eq("R3 R6 R7 model vec", int'(vec), m_vec);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d; cyc(); we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        addr = a; #0.5; eq(tag, int'(rdata), exp);
    endtask

    task automatic do_ack();
        ack = 1'b1; cyc(); ack = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        eq("R1 req after reset", int'(req), 0);
        eq("R1 vec after reset", int'(vec), 0);
        rd(2'd0, 32'h3FFFC, "R1 mask after reset");
        rd(2'd1, 0, "R1 pending after reset");
        // R10 unused addresses read zero
        rd(2'd2, 0, "R10 addr2 reads zero");
        rd(2'd3, 0, "R10 addr3 reads zero");
        // R4 nonmaskable mask bits stay zero
        wr(2'd0, 32'h3FFFF);
        rd(2'd0, 32'h3FFFC, "R4 mask bits 0,1 not writable");
        wr(2'd0, 32'h0);
        rd(2'd0, 0, "R10 mask written zero");

        // R2 R3 request line 5 -> code 10
        irq[5] = 1'b1; cyc(); irq[5] = 1'b0;
        eq("R2 irq5 req", int'(req), 1);
        eq("R3 irq5 code", int'(vec), 10);
        rd(2'd1, 1 << 10, "R2 irq5 pending");
        // R6 watchdog arrives while held
        wdt = 1'b1; cyc(); wdt = 1'b0;
        eq("R6 vec held", int'(vec), 10);
        rd(2'd1, (1 << 10) | 1, "R2 wdt pending");
        // R7 ack hands over next edge
        do_ack();
        eq("R7 next code", int'(vec), 0);
        rd(2'd1, 1, "R7 only presented cleared");
        do_ack();
        eq("R7 req drops", int'(req), 0);
        do_ack();
        eq("R7 stray ack ignored", int'(req), 0);
        rd(2'd1, 0, "R7 stray ack pending");

        // R5 mask blocks request, not latching
        wr(2'd0, 32'h3FFFC);
        ovf = 1'b1; cyc(); ovf = 1'b0;
        eq("R5 masked no req", int'(req), 0);
        rd(2'd1, 4, "R5 masked still pending");
        // R4 external pin ignores mask
        nmi = 1'b1; cyc(); nmi = 1'b0;
        eq("R4 nmi req", int'(req), 1);
        eq("R4 nmi code", int'(vec), 1);
        do_ack();
        eq("R5 masked after ack", int'(req), 0);
        wr(2'd0, 32'h0);
        eq("R5 unmask req", int'(req), 1);
        eq("R5 unmask code", int'(vec), 2);
        do_ack();
        // R9 software trigger
        wr(2'd2, 32'h1);
        eq("R9 sw req", int'(req), 1);
        eq("R9 sw code", int'(vec), 4);
        rd(2'd1, 16, "R9 sw pending");
        do_ack();

        // R8 write-one-to-clear
        wr(2'd0, 32'h3FFFC);
        irq[0] = 1'b1; irq[12] = 1'b1; cyc(); irq[0] = 1'b0; irq[12] = 1'b0;
        rd(2'd1, (1 << 5) | (1 << 17), "R8 two pending");
        wr(2'd1, 1 << 5);
        rd(2'd1, 1 << 17, "R8 one cleared");
        wr(2'd0, 32'h0);
        eq("R8 code 17 presented", int'(vec), 17);
        wr(2'd1, 1 << 17);
        eq("R8 clear of presented drops req", int'(req), 0);

        // R2 held level does not relatch
        irq[3] = 1'b1; cyc();
        eq("R2 level first code", int'(vec), 8);
        do_ack();
        cyc(); cyc();
        eq("R2 held level no relatch", int'(req), 0);
        irq[3] = 1'b0; cyc();

        // R3 full ordering
        irq = '1; ovf = 1'b1; unf = 1'b1; cyc();
        irq = '0; ovf = 1'b0; unf = 1'b0;
        for (int k = 0; k < 15; k++) begin
            int e;
            e = (k < 2) ? k + 2 : k + 3;
            eq("R3 order code", int'(vec), e);
            do_ack();
        end
        eq("R3 order all retired", int'(req), 0);
        cyc();
        finish_run();
    end
endmodule